// File: doc/BRIEF.md
# Serial Register-Access Target

This block is a two-wire serial bus target (I2C, standard and fast mode framing) that gives a bus host read and write access to a small bank of 8-bit registers. It watches the clock and data lines for START and STOP, shifts in a 7-bit device address and a direction bit, and acknowledges only its own fixed address. In a write transfer, the first byte sets an internal register pointer and each later byte lands in the register that the pointer selects. In a read transfer, the block returns the register at the pointer. The pointer steps forward after every byte in both directions.

The bus pins are sampled by a fast system clock. They pass through a short synchronizer, and all edge detection happens in the system clock domain. There is no glitch filter on the clock line, so every clean transition counts as a bit edge. The data line is open-drain. The block drives a single pull-low output, and the board combines it with the host's drive. The register contents are exported in parallel so that the rest of the chip can use them.

A STOP returns the logic to idle from any state, and a START restarts address reception from any state. Either one discards a byte that was only partly shifted in.

Top module: `i2c_reg_slave`

## Requirements
- R1: A START (data falling while clock is high) restarts address reception from any state, and a STOP (data rising while clock is high) returns the block to idle from any state. After either event the data line is released.
- R2: Only the address 7'b1101011 (0x6B) is acknowledged. Any other address gets no acknowledge, and the data line stays released for the rest of that transfer.
- R3: The block changes its data-line drive only while the clock is low. An acknowledge holds the line low for the whole high phase of the ninth clock.
- R4: Direction bit 0 means a host write. The first byte after the address loads the pointer, each later byte is stored at the pointer, and the pointer then increments. Every byte is acknowledged.
- R5: Direction bit 1 means a host read. The register at the pointer is sent most significant bit first, and the pointer increments after each byte.
- R6: Registers are mapped at pointer values 0 to NUM_REGS-1 (0 to 3 by default). A read of any other pointer value returns 0xFF. A write to any other pointer value is acknowledged but changes no register.
- R7: When the host does not acknowledge a read byte (data high during the ninth clock), the block releases the data line and drives nothing until the next START or STOP.
- R8: A repeated START is accepted in place of a STOP, and the pointer value is kept across it. This allows the sequence: set the pointer, repeated START, then read.
- R9: After reset, all registers are 0x00 and the data line is released.
- R10: When a STOP or START arrives in the middle of a data byte, that partial byte is discarded and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| sda_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | NUM_REGS*8 | Register contents, register 0 in bits 7:0 |

## Verification
The hardest situations to reach are the aborts: a START or STOP that lands after only a few bits of a data byte, because the host must deliberately break the 9-bit framing. The bench's bus tasks can clock out an arbitrary number of single bits and then issue a STOP or a repeated START mid-byte. The bench then checks that the register bank is unchanged and that the pointer survives into the next read. The host-NACK release is reached by clocking extra bits after the NACK and checking that the wired data line never goes low.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } bus_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES:0] scl_sr, sda_sr;
  logic scl_cur, scl_prev, sda_cur, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-1:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_cur  = scl_sr[SYNC_STAGES-1];
  assign scl_prev = scl_sr[SYNC_STAGES];
  assign sda_cur  = sda_sr[SYNC_STAGES-1];
  assign sda_prev = sda_sr[SYNC_STAGES];

  assign scl_o      = scl_cur;
  assign sda_o      = sda_cur;
  assign scl_rise_o = scl_cur & ~scl_prev;
  assign scl_fall_o = ~scl_cur & scl_prev;
  // data edge while clock held high
  assign start_o    = scl_cur & scl_prev & ~sda_cur & sda_prev;
  assign stop_o     = scl_cur & scl_prev & sda_cur & ~sda_prev;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned PTR_W    = 8,
  parameter int unsigned DW       = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [PTR_W-1:0]       wr_idx_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic [PTR_W-1:0]       rd_idx_i,
  output logic [DW-1:0]          rd_data_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic [DW-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == PTR_W'(g))     regs_q[g] <= wr_data_i;
    end
    assign regs_o[g*DW +: DW] = regs_q[g];
  end

  // unmapped pointer reads all ones
  always_comb begin
    rd_data_o = '1;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx_i == PTR_W'(i)) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h6B,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned PTR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [PTR_W-1:0]  rd_idx_o,
  output logic              sda_low_o,
  output bus_state_e        state_o
);
  bus_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              first_q, rw_q, mack_q, pull_q;
  logic              byte_done;

  assign byte_done = scl_fall_i && (cnt_q == 4'd8);
  assign wr_en_o   = (state_q == ST_WR_BYTE) && byte_done && !first_q &&
                     !start_i && !stop_i && (ptr_q < PTR_W'(NUM_REGS));
  assign wr_idx_o  = ptr_q;
  assign wr_data_o = sh_q;
  assign rd_idx_o  = ptr_q;
  assign sda_low_o = pull_q;
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      first_q <= 1'b1;
      pull_q  <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            if (sh_q[7:1] == DEV_ADDR) begin
              rw_q    <= sh_q[0];
              pull_q  <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              sh_q    <= rd_data_i;
              pull_q  <= ~rd_data_i[BYTE_W-1];
              state_q <= ST_RD_BYTE;
            end else begin
              pull_q  <= 1'b0;
              state_q <= ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            pull_q  <= 1'b1;
            state_q <= ST_WR_ACK;
            first_q <= 1'b0;
            ptr_q   <= first_q ? PTR_W'(sh_q) : ptr_q + 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            pull_q  <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            pull_q  <= 1'b0;
            ptr_q   <= ptr_q + 1'b1;
            state_q <= ST_RD_ACK;
          end else if (scl_fall_i && cnt_q != 4'd0) begin
            sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
            pull_q <= ~sh_q[BYTE_W-2];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            cnt_q <= '0;
            if (mack_q) begin
              sh_q    <= rd_data_i;
              pull_q  <= ~rd_data_i[BYTE_W-1];
              state_q <= ST_RD_BYTE;
            end else begin
              pull_q  <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
        end
        default: pull_q <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h6B,
  parameter int unsigned NUM_REGS    = 4,
  parameter int unsigned PTR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_low_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;
  bus_state_e        state;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .rd_idx_o(rd_idx),
    .sda_low_o, .state_o(state)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .DW(BYTE_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .regs_o
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
  import i2c_reg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned PTR_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              sda_low_o,
  input logic              wr_en,
  input logic [PTR_W-1:0]  wr_idx,
  input logic [PTR_W-1:0]  rd_idx,
  input logic [BYTE_W-1:0] rd_data,
  input bus_state_e        state
);
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_low_o); // R1
  AST_START_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> !sda_low_o); // R1
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_low_o) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_low_o); // R7
  AST_WR_MAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_idx < PTR_W'(NUM_REGS))); // R6
  AST_UNMAPPED_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx >= PTR_W'(NUM_REGS)) |-> (rd_data == 8'hFF)); // R6
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_low_o(sda_low_o), .wr_en(wr_en), .wr_idx(wr_idx),
  .rd_idx(rd_idx), .rd_data(rd_data), .state(state)
);

// File: tb/sim_i2c_reg_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg_slave;
  localparam int HALF = 16;
  localparam int NREG = 4;
  localparam logic [6:0] ADDR = 7'h6B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_low;
  logic [NREG*8-1:0] regs;
  wire  sda_line = sda_m & ~sda_low;

  int n_chk = 0, n_err = 0, viol = 0;
  logic [7:0] exp_regs [NREG];
  int  mdl_ptr = 0;
  bit  cmp_en = 1'b0;
  logic prev_low = 1'b0;

  always #2.5 clk = ~clk;

  i2c_reg_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_low_o(sda_low), .regs_o(regs)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_flat();
    logic [31:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = exp_regs[i];
    return f;
  endfunction

  function automatic logic [7:0] exp_read(input int p);
    return (p < NREG) ? exp_regs[p] : 8'hFF;
  endfunction

  // reference register image compared on every clock while the bus is idle (R4)
  always @(negedge clk) begin
    if (rst_n && cmp_en) chk(regs == exp_flat(), "R4 image", regs, exp_flat());
    if (rst_n && scl_m && (sda_low != prev_low)) viol++;
    prev_low = sda_low;
  end

  task automatic bit_cycle(input logic b, output logic mid, output logic all_low);
    sda_m = b;
    repeat (HALF) @(negedge clk);
    scl_m = 1'b1;
    all_low = 1'b1;
    mid = 1'b1;
    for (int k = 0; k < HALF; k++) begin
      @(negedge clk);
      if (sda_line) all_low = 1'b0;
      if (k == HALF / 2) mid = sda_line;
    end
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    cmp_en = 1'b0;
    sda_m = 1'b1;
    repeat (HALF) @(negedge clk);
    scl_m = 1'b1;
    repeat (HALF) @(negedge clk);
    sda_m = 1'b0;
    repeat (HALF) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    repeat (HALF) @(negedge clk);
    scl_m = 1'b1;
    repeat (HALF) @(negedge clk);
    sda_m = 1'b1;
    repeat (HALF) @(negedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    logic m, a;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], m, a);
    bit_cycle(1'b1, m, a);
    ack = a;
  endtask

  task automatic get_byte(input bit host_ack, output logic [7:0] d);
    logic m, a;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, m, a);
      d[i] = m;
    end
    bit_cycle(~host_ack, m, a);
  endtask

  task automatic wr_data(input logic [7:0] b, input string req);
    bit ack;
    put_byte(b, ack);
    chk(ack, req, {31'd0, ack}, 32'd1);
    if (mdl_ptr < NREG) exp_regs[mdl_ptr] = b;
    mdl_ptr = (mdl_ptr + 1) % 256;
  endtask

  task automatic set_ptr(input logic [7:0] p, input string req);
    bit ack;
    put_byte({ADDR, 1'b0}, ack);
    chk(ack, req, {31'd0, ack}, 32'd1);
    put_byte(p, ack);
    chk(ack, req, {31'd0, ack}, 32'd1);
    mdl_ptr = int'(p);
  endtask

  task automatic rd_check(input bit host_ack, input string req);
    logic [7:0] d;
    get_byte(host_ack, d);
    chk(d == exp_read(mdl_ptr), req, d, exp_read(mdl_ptr));
    mdl_ptr = (mdl_ptr + 1) % 256;
  endtask

  task automatic run_all();
    bit ack;
    logic m, a;
    logic [7:0] d;
    bit any_low;
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(regs == '0, "R9 regs", regs, 32'd0);
    chk(sda_low == 1'b0, "R9 sda", sda_low, 32'd0);
    cmp_en = 1'b1;

    // foreign address on write
    bus_start();
    put_byte({7'h55, 1'b0}, ack);
    chk(!ack, "R2 foreign write", ack, 32'd0);
    bus_stop();

    // write two registers
    bus_start();
    set_ptr(8'h01, "R4 ptr");
    wr_data(8'hA5, "R4 data");
    wr_data(8'h3C, "R4 data");
    bus_stop();
    chk(regs[15:8] == 8'hA5, "R4 reg1", regs[15:8], 32'hA5);
    chk(regs[23:16] == 8'h3C, "R4 reg2", regs[23:16], 32'h3C);

    // pointer then repeated start, read two, NACK
    bus_start();
    set_ptr(8'h01, "R8 ptr");
    bus_start();
    put_byte({ADDR, 1'b1}, ack);
    chk(ack, "R8 restart ack", ack, 32'd1);
    rd_check(1'b1, "R5 byte0");
    rd_check(1'b0, "R5 byte1");
    any_low = 1'b0;
    for (int i = 0; i < 9; i++) begin
      bit_cycle(1'b1, m, a);
      if (!m) any_low = 1'b1;
    end
    chk(!any_low, "R7 released after NACK", any_low, 32'd0);
    bus_stop();

    // writes crossing into unmapped space
    bus_start();
    set_ptr(8'h03, "R6 ptr");
    wr_data(8'h77, "R6 data");
    wr_data(8'h88, "R6 unmapped");
    wr_data(8'h99, "R6 unmapped");
    bus_stop();
    chk(regs == exp_flat(), "R6 regs", regs, exp_flat());

    // reads crossing into unmapped space
    bus_start();
    set_ptr(8'h03, "R6 ptr");
    bus_start();
    put_byte({ADDR, 1'b1}, ack);
    chk(ack, "R8 ack", ack, 32'd1);
    rd_check(1'b1, "R5 reg3");
    rd_check(1'b1, "R6 read FF");
    rd_check(1'b0, "R6 read FF");
    bus_stop();

    // START in the middle of a data byte keeps pointer, drops partial byte
    bus_start();
    set_ptr(8'h02, "R1 ptr");
    for (int i = 0; i < 3; i++) bit_cycle(1'b1, m, a);
    bus_start();
    put_byte({ADDR, 1'b1}, ack);
    chk(ack, "R1 restart mid-byte", ack, 32'd1);
    rd_check(1'b0, "R1 read after restart");
    bus_stop();
    chk(regs == exp_flat(), "R10 start abort", regs, exp_flat());

    // STOP in the middle of a data byte
    bus_start();
    set_ptr(8'h00, "R10 ptr");
    for (int i = 0; i < 5; i++) bit_cycle(1'b1, m, a);
    bus_stop();
    chk(regs[7:0] == 8'h00, "R10 stop abort", regs[7:0], 32'h0);

    // recovery after abort
    bus_start();
    set_ptr(8'h00, "R1 recovery");
    wr_data(8'h5A, "R1 recovery data");
    bus_stop();
    chk(regs[7:0] == 8'h5A, "R1 recovery reg0", regs[7:0], 32'h5A);

    // foreign address on read: no ack, no drive
    bus_start();
    put_byte({7'h6A, 1'b1}, ack);
    chk(!ack, "R2 foreign read", ack, 32'd0);
    get_byte(1'b0, d);
    chk(d == 8'hFF, "R2 silent", d, 32'hFF);
    bus_stop();

    chk(viol == 0, "R3 drive changes with clock low", viol, 32'd0);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    cmp_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule